// File: doc/BRIEF.md
# UART Modem Control and Status

This block holds the modem-control and modem-status state of a 16550-style serial port. Software writes a small control word that drives four modem output pins (data terminal ready, request to send, and two general-purpose outputs) and selects a loopback test mode. The four modem input pins (clear to send, data set ready, carrier detect, ring indicator) arrive already synchronized. They are sampled every clock into the status word.

Each status read returns the current pin levels together with four sticky change flags. Three flags record any transition of CTS, DSR and DCD. The ring flag records only a falling edge of RI. A read strobe clears the flags on the following clock edge. A single `any_delta` output feeds the port's interrupt logic.

In loopback, the output pins are forced inactive. A status read then shows the control bits cross-mapped onto the input positions, with no change flags. External input activity during loopback is tracked silently, so it raises no flags, including after loopback ends.

Top module: `uart_modem_ctl_sts`

## Requirements
- R1: After reset the control readback is 0x08, only `out2_o` is high, the status read value is 0xB0 (DCD, DSR, CTS asserted) and `any_delta` is low.
- R2: A control write stores `ctl_wdata[4:0]` (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 LOOP), and bits 7:5 are ignored. The readback `ctl_q` shows the stored value with bits 7:5 zero from the clock edge of the write.
- R3: With LOOP clear, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0, 1, 2 and 3.
- R4: With LOOP clear, status bits 7..4 hold DCD, RI, DSR and CTS as sampled at the previous clock edge.
- R5: Status bits 3, 1 and 0 are set by any change of DCD, DSR and CTS respectively between two consecutive samples. Once set, they stay set until cleared by a read.
- R6: Status bit 2 is set only when sampled RI goes from 1 to 0. A rising RI sets no flag.
- R7: A clock edge with `sts_rd` high and LOOP clear clears bits 3:0 and leaves bits 7:4 following the pins. A pin change sampled at that same edge still sets its flag.
- R8: `any_delta` is high exactly when at least one of the four stored change flags is set.
- R9: With LOOP set, all four output pins are low. The status read value is {OUT2, OUT1, DTR, RTS, 4'b0000}, taken from control bits 3, 2, 0 and 1.
- R10: Input changes while LOOP is set set no flag. On leaving loopback, the flags reflect no change that happened during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write enable |
| ctl_wdata | input | 8 | Control write data |
| ctl_q | output | 8 | Stored control word, bits 7:5 zero |
| sts_rd | input | 1 | Status read strobe; clears flags at the next edge |
| sts_rdata | output | 8 | Status read value |
| any_delta | output | 1 | OR of the stored change flags |
| cts_i | input | 1 | Clear to send, synchronized, high = asserted |
| dsr_i | input | 1 | Data set ready, synchronized |
| dcd_i | input | 1 | Carrier detect, synchronized |
| ri_i | input | 1 | Ring indicator, synchronized |
| dtr_o | output | 1 | Data terminal ready out |
| rts_o | output | 1 | Request to send out |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |

## Verification
Every ordered pair of 4-bit pin states (old, new) is applied. Between the two states there is a clearing read and an idle cycle. This separates the XOR flags from the falling-only ring flag and shows the flags are sticky. All 256 control write values are applied with the output pins observed. This exposes bit-mapping swaps and missing masking of bits 7:5. All 16 non-loop control values are repeated with LOOP set, and the pins are toggled meanwhile. This checks the cross-mapping and the silent tracking of inputs. A read coinciding with a pin change checks that a new flag wins over the clear.

// File: rtl/uart_modem_ctl_sts.sv
module uart_modem_ctl_sts #(
  parameter logic [4:0] CTL_RST = 5'h08,
  parameter logic [3:0] PIN_RST = 4'hB
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_q,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata,
  output logic       any_delta,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       dcd_i,
  input  logic       ri_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       out1_o,
  output logic       out2_o
);

  logic [4:0] ctl;
  logic [3:0] pin_s, dlt;
  logic [3:0] pins, chg;
  logic       loop;

  assign loop = ctl[4];
  assign pins = {dcd_i, ri_i, dsr_i, cts_i};
  assign chg  = loop ? 4'h0 :
                {pin_s[3] ^ pins[3], pin_s[2] & ~pins[2],
                 pin_s[1] ^ pins[1], pin_s[0] ^ pins[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl   <= CTL_RST;
      pin_s <= PIN_RST;
      dlt   <= 4'h0;
    end else begin
      if (ctl_we) ctl <= ctl_wdata[4:0];
      pin_s <= pins;
      dlt   <= ((sts_rd && !loop) ? 4'h0 : dlt) | chg;
    end
  end

  assign ctl_q     = {3'b000, ctl};
  assign any_delta = |dlt;
  assign sts_rdata = loop ? {ctl[3], ctl[2], ctl[0], ctl[1], 4'h0} : {pin_s, dlt};
  assign dtr_o     = ctl[0] & ~loop;
  assign rts_o     = ctl[1] & ~loop;
  assign out1_o    = ctl[2] & ~loop;
  assign out2_o    = ctl[3] & ~loop;

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd |=> ((dlt & $past(dlt)) == $past(dlt)));
  // R6
  ring_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt[2]) |-> ($past(ri_i) == 1'b0 && $past(pin_s[2]) == 1'b1));
  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !loop && pins == pin_s) |=> dlt == 4'h0);
  // R9
  loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop |-> {dtr_o, rts_o, out1_o, out2_o} == 4'h0);
  // R10
  loop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop |=> (dlt & ~$past(dlt)) == 4'h0);

endmodule

// File: tb/sim_uart_modem_ctl_sts.sv
module sim_uart_modem_ctl_sts;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, sts_rd = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] ctl_q, sts_rdata;
  logic any_delta;
  logic [3:0] pv = 4'hB;
  logic dtr_o, rts_o, out1_o, out2_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_modem_ctl_sts u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .sts_rd(sts_rd), .sts_rdata(sts_rdata), .any_delta(any_delta),
    .cts_i(pv[0]), .dsr_i(pv[1]), .dcd_i(pv[3]), .ri_i(pv[2]),
    .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic rd_clear();
    sts_rd = 1; step(); sts_rd = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; step(); ctl_we = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst_n = 1; #0;
    // R1 reset state
    chk("R1", ctl_q, 8'h08);
    chk("R1", {dtr_o, rts_o, out1_o, out2_o}, 4'b0001);
    chk("R1", sts_rdata, 8'hB0);
    chk("R1", any_delta, 0);

    // R2 R3 control write sweep
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R2", ctl_q, {3'b0, v[4:0]});
      if (!v[4]) chk("R3", {out2_o, out1_o, rts_o, dtr_o}, v[3:0]);
      else       chk("R9", {out2_o, out1_o, rts_o, dtr_o}, 4'h0);
    end
    wr(8'h00);

    // R4 R5 R6 R8 all pin transitions
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        logic [3:0] ov, nv, ed;
        ov = o[3:0]; nv = n[3:0];
        pv = ov; step();
        rd_clear();
        pv = nv; step(); step();
        ed = {ov[3] ^ nv[3], ov[2] & ~nv[2], ov[1] ^ nv[1], ov[0] ^ nv[0]};
        chk("R5_R6", sts_rdata, {nv, ed});
        chk("R8", any_delta, ed != 0);
        rd_clear();
        // R7 clear leaves pins
        chk("R7", sts_rdata, {nv, 4'h0});
        chk("R8", any_delta, 0);
      end
    end

    // R7 change during read cycle wins
    pv = 4'h0; step(); rd_clear();
    pv = 4'h1; sts_rd = 1; step(); sts_rd = 0;
    chk("R7", sts_rdata, 8'h11);
    rd_clear();

    // R9 R10 loopback sweep
    for (int m = 0; m < 16; m++) begin
      logic [7:0] ex;
      wr({4'h1, m[3:0]});
      pv = ~pv; step();
      ex = {m[3], m[2], m[0], m[1], 4'h0};
      chk("R9", sts_rdata, ex);
      chk("R9", {dtr_o, rts_o, out1_o, out2_o}, 4'h0);
      chk("R10", any_delta, 0);
    end
    pv = 4'hA; step();
    wr(8'h00); step();
    chk("R10", sts_rdata, 8'hA0);
    chk("R10", any_delta, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule